// File: doc/BRIEF.md
# Test Access Port Instruction Register and Decoder

This block is the serial test-access front end of a scan-testable chip. It runs the sixteen-state test access port controller from a test clock and a mode-select pin. It also holds a four-bit instruction, which is shifted in serially and then moved into a parallel hold stage. The held instruction is decoded into data-register selection, a pad output-override enable and an internal system reset request. A one-bit bypass register sits inside the block. The boundary-scan chain sits outside, and the block drives its capture, shift and update strobes and takes back its serial output.

Three opcodes are defined: EXTEST, SAMPLE/PRELOAD and BYPASS. Any other value, including the reserved opcodes at the top of the range, acts exactly like BYPASS. While EXTEST is held, the pads are driven from the boundary-scan update latches and the core logic is kept in reset.

Top module: `jtag_ir_decode`

## Requirements
- R1: While `trst_n` is low, the controller is in Test-Logic-Reset and the held instruction `instr` is 4'hF (BYPASS). In this state `sel_bypass`=1, `sel_bscan`=0, `pad_override`=0, `sys_reset_req`=0 and `tdo_oe`=0.
- R2: Five or more rising edges of `tck` with `tms`=1 bring the controller to Test-Logic-Reset from any state. The falling edge that follows loads BYPASS (4'hF) into `instr`.
- R3: In Capture-IR the shift stage loads 4'b0001. In Shift-IR each rising edge shifts `tdi` in at the MSB end. On each falling edge `tdo` presents the stage's LSB, so the captured pattern leaves as 1,0,0,0. `tdo_oe` is 1 only in Shift-IR and Shift-DR.
- R4: `instr` changes only on a falling edge of `tck` while the controller is in Update-IR (or Test-Logic-Reset). Shifting a new opcode leaves `instr` unchanged until that edge.
- R5: Opcode 4'h0 (EXTEST) gives `sel_bscan`=1, `sel_bypass`=0, `pad_override`=1 and `sys_reset_req`=1.
- R6: Opcode 4'h1 (SAMPLE/PRELOAD) gives `sel_bscan`=1, `sel_bypass`=0, `pad_override`=0 and `sys_reset_req`=0.
- R7: Every opcode from 4'h2 to 4'hF gives `sel_bypass`=1, `sel_bscan`=0, `pad_override`=0 and `sys_reset_req`=0. This includes the reserved 4'hC, 4'hD and 4'hE.
- R8: With bypass selected, Capture-DR clears the bypass bit. In Shift-DR, `tdo` then returns 0 followed by the `tdi` bits delayed by one clock.
- R9: With the boundary-scan register selected, `tdo` in Shift-DR carries `dr_tdo` sampled on the falling edge. `dr_capture`, `dr_shift` and `dr_update` are high in Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| dr_tdo | input | 1 | Serial return from the boundary-scan chain |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Pad driver enable for `tdo`; the pad floats when low |
| instr | output | 4 | Active (held) instruction |
| sel_bypass | output | 1 | Bypass register is the active data register |
| sel_bscan | output | 1 | Boundary-scan register is the active data register |
| pad_override | output | 1 | Pads driven from boundary-scan update latches |
| sys_reset_req | output | 1 | Reset request to the core logic |
| dr_capture | output | 1 | Controller in Capture-DR |
| dr_shift | output | 1 | Controller in Shift-DR |
| dr_update | output | 1 | Controller in Update-DR |

## Verification
The hardest situation to reach from the ports is the split between the rising-edge shift and the falling-edge hold update. The bench must observe `instr` after a full new opcode has been shifted in but before the Update-IR falling edge, and then again just after it. The driver walks the controller through Exit1-IR and checks the old instruction there. It then steps through Update-IR and checks the new one. The serial stream on `tdo` is predicted bit by bit into a scoreboard queue, and a falling-edge monitor drains that queue whenever `tdo_oe` is high. This catches both a wrong shift direction and an output enable that opens one cycle early or late.

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode #(
  parameter int IR_W = 4,
  parameter logic [IR_W-1:0] OP_EXTEST = 4'h0,
  parameter logic [IR_W-1:0] OP_SAMPLE = 4'h1,
  parameter logic [IR_W-1:0] OP_BYPASS = 4'hF,
  parameter logic [IR_W-1:0] IR_CAPTURE = 4'b0001
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic            dr_tdo,
  output logic            tdo,
  output logic            tdo_oe,
  output logic [IR_W-1:0] instr,
  output logic            sel_bypass,
  output logic            sel_bscan,
  output logic            pad_override,
  output logic            sys_reset_req,
  output logic            dr_capture,
  output logic            dr_shift,
  output logic            dr_update
);

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR,
    S_UPD_DR, S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
  } tap_t;

  tap_t state, nxt;
  logic [IR_W-1:0] ir_sh, ir_hold;
  logic byp, tdo_q, oe_q;

  always_comb begin
    unique case (state)
      S_TLR:    nxt = tms ? S_TLR    : S_RTI;
      S_RTI:    nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nxt = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nxt = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nxt = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nxt = tms ? S_UPD_DR : S_PAU_DR;
      S_PAU_DR: nxt = tms ? S_EX2_DR : S_PAU_DR;
      S_EX2_DR: nxt = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nxt = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nxt = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nxt = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nxt = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nxt = tms ? S_UPD_IR : S_PAU_IR;
      S_PAU_IR: nxt = tms ? S_EX2_IR : S_PAU_IR;
      S_EX2_IR: nxt = tms ? S_UPD_IR : S_SH_IR;
      default:  nxt = tms ? S_SEL_DR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nxt;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                ir_sh <= IR_CAPTURE;
    else if (state == S_CAP_IR) ir_sh <= IR_CAPTURE;
    else if (state == S_SH_IR)  ir_sh <= {tdi, ir_sh[IR_W-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                ir_hold <= OP_BYPASS;
    else if (state == S_TLR)    ir_hold <= OP_BYPASS;
    else if (state == S_UPD_IR) ir_hold <= ir_sh;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                byp <= 1'b0;
    else if (state == S_CAP_DR) byp <= 1'b0;
    else if (state == S_SH_DR)  byp <= tdi;

  assign instr         = ir_hold;
  assign sel_bscan     = (ir_hold == OP_EXTEST) || (ir_hold == OP_SAMPLE);
  assign sel_bypass    = !sel_bscan;
  assign pad_override  = (ir_hold == OP_EXTEST);
  assign sys_reset_req = pad_override;
  assign dr_capture    = (state == S_CAP_DR);
  assign dr_shift      = (state == S_SH_DR);
  assign dr_update     = (state == S_UPD_DR);

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (state == S_SH_IR) || (state == S_SH_DR);
      if (state == S_SH_IR)      tdo_q <= ir_sh[0];
      else if (state == S_SH_DR) tdo_q <= sel_bscan ? dr_tdo : byp;
    end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

  // R2
  tlr_bypass_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR && $past(state) == S_TLR) |-> ir_hold == OP_BYPASS);

  // R4
  hold_only_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && state != S_TLR) |-> $stable(ir_hold));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> ir_sh == IR_CAPTURE);

  // R3
  oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == S_SH_IR || state == S_SH_DR));

  // R8
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_SH_DR) |=> byp == $past(tdi));

  // R5
  extest_ctl_chk: assert property (@(posedge tck) disable iff (!trst_n)
    pad_override |-> (sel_bscan && !sel_bypass && sys_reset_req));

endmodule

// File: tb/jtag_ir_decode_tb.sv
module jtag_ir_decode_tb;
  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, dr_tdo = 1'b0;
  logic tdo, tdo_oe, sel_bypass, sel_bscan, pad_override, sys_reset_req;
  logic dr_capture, dr_shift, dr_update;
  logic [3:0] instr;
  int tests = 0, fails = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #5 tck = ~tck;

  jtag_ir_decode u_dut (.tck, .trst_n, .tms, .tdi, .dr_tdo, .tdo, .tdo_oe, .instr,
    .sel_bypass, .sel_bscan, .pad_override, .sys_reset_req,
    .dr_capture, .dr_shift, .dr_update);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge tck) begin
    #2;
    if (trst_n && tdo_oe) begin
      if (exp_q.size() == 0) chk("R3 unexpected tdo_oe", 1, 0);
      else begin
        string t = tag_q.pop_front();
        chk(t, tdo, exp_q.pop_front());
      end
    end
  end

  task automatic step(bit m, bit d);
    @(negedge tck); #1;
    tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(logic [3:0] op, logic [3:0] old);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(i == 0);
      tag_q.push_back("R3 ir tdo");
    end
    for (int i = 0; i < 4; i++) step(i == 3, op[i]);
    chk("R4 instr before update", instr, old);
    step(1, 0); step(0, 0);
    chk("R4 instr after update", instr, op);
  endtask

  task automatic scan_dr(logic [7:0] d, bit bscan);
    step(1, 0); step(0, 0);
    chk("R9 dr_capture", dr_capture, 1);
    step(0, 0);
    chk("R9 dr_shift", dr_shift, 1);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back(bscan ? dr_tdo : (i == 0 ? 1'b0 : d[i-1]));
      tag_q.push_back(bscan ? "R9 bscan tdo" : "R8 bypass tdo");
    end
    for (int i = 0; i < 8; i++) step(i == 7, d[i]);
    step(1, 0);
    chk("R9 dr_update", dr_update, 1);
    step(0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #22;
    chk("R1 instr", instr, 4'hF);
    chk("R1 sel_bypass", sel_bypass, 1);
    chk("R1 sel_bscan", sel_bscan, 0);
    chk("R1 override", pad_override, 0);
    chk("R1 reset req", sys_reset_req, 0);
    chk("R1 tdo_oe", tdo_oe, 0);
    @(negedge tck); #1 trst_n = 1;
    step(0, 0);

    load_ir(4'h0, 4'hF);
    chk("R5 sel_bscan", sel_bscan, 1);
    chk("R5 sel_bypass", sel_bypass, 0);
    chk("R5 override", pad_override, 1);
    chk("R5 reset req", sys_reset_req, 1);
    dr_tdo = 1;
    scan_dr(8'h00, 1);

    for (int k = 0; k < 6; k++) step(1, 0);
    chk("R2 tms reset instr", instr, 4'hF);
    chk("R2 reset req cleared", sys_reset_req, 0);
    step(0, 0);

    load_ir(4'h1, 4'hF);
    chk("R6 sel_bscan", sel_bscan, 1);
    chk("R6 override", pad_override, 0);
    chk("R6 reset req", sys_reset_req, 0);
    dr_tdo = 0;
    scan_dr(8'hFF, 1);

    for (int op = 2; op < 16; op++) begin
      load_ir(op[3:0], (op == 2) ? 4'h1 : 4'(op - 1));
      chk("R7 sel_bypass", sel_bypass, 1);
      chk("R7 sel_bscan", sel_bscan, 0);
      chk("R7 override", pad_override, 0);
      chk("R7 reset req", sys_reset_req, 0);
    end
    dr_tdo = 1;
    scan_dr(8'hB5, 0);
    scan_dr(8'h6A, 0);

    repeat (3) @(posedge tck);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule